// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in the same cycle, whether an instruction that touches a control and status register may go ahead or must trap as an illegal instruction. It looks at the 12-bit CSR address, the kind of access, and whether the source operand is nonzero. From these it produces two outputs. One says whether the address belongs to the supported set. The other says whether the access raises an exception.

The supported set has three groups. The first is the machine identification registers. The second is the user-level counter and timer registers, with their upper halves. The third is the machine-level counter-enable, performance-counter and event-selector registers. Reads of any counter-related register are always legal, including performance counters that have no storage behind them. Writes follow the read-only encoding of the address space.

The block sits in the decode or execute stage of a machine-mode-only core. It holds no state. Counter storage, the timer source and privilege handling belong to other blocks.

Top module: `csr_perm_check`

## Requirements
- R1: A write intent to any identification register (0xF11 to 0xF14) raises an exception. A pure read of these registers does not raise one.
- R2: A write intent to the cycle or retired-instruction counters (0xC00, 0xC02) or to their upper halves (0xC80, 0xC82) raises an exception.
- R3: Reads of the timer register 0xC01 and of its upper half 0xC81 are legal and defined.
- R4: Reads of user performance counters 3 to 31 (0xC03 to 0xC1F) and of their upper halves (0xC83 to 0xC9F) are legal and defined.
- R5: Reads of these registers are legal and defined: the counter-enable register 0x306, the machine performance counters 0xB03 to 0xB1F and 0xB83 to 0xB9F, and the event selectors 0x323 to 0x33F.
- R6: Write intents to every address listed in R5 are legal.
- R7: `op_kind` uses this encoding: 00 read, 01 write, 10 set, 11 clear. A write always carries write intent. Set and clear carry write intent only when `src_nonzero` is 1. A read never carries write intent.
- R8: Any address outside the supported set gives `csr_defined`=0 and `raise_exc`=1, for every access kind. Examples are 0xB00, 0x320 and 0xF15.
- R9: `csr_defined` is 1 exactly for the addresses listed in R1 to R5, whatever the access kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | CSR address field of the instruction |
| op_kind | input | 2 | Access kind: 00 read, 01 write, 10 set, 11 clear |
| src_nonzero | input | 1 | Source register index or immediate is nonzero |
| csr_defined | output | 1 | Address is in the supported set |
| raise_exc | output | 1 | Access raises an illegal-instruction exception |

## Verification
The bench builds the block with its default parameters. These are the full performance-counter range up to index 31 and four identification registers. The boundaries of every group can therefore be probed, both the first and last legal index and the addresses just outside each group. With these values the gaps at counter indices 0 to 2 in the machine counter and event ranges, and the address just past the identification block, are all reachable.

// File: rtl/csr_perm_check.sv
module csr_perm_check #(
  parameter int         HPM_TOP  = 31,
  parameter logic [11:0] ID_BASE = 12'hF11,
  parameter int         ID_COUNT = 4
) (
  input  logic [11:0] csr_addr,
  input  logic [1:0]  op_kind,
  input  logic        src_nonzero,
  output logic        csr_defined,
  output logic        raise_exc
);
  localparam logic [4:0]  TOP5   = 5'(HPM_TOP);
  localparam logic [11:0] ID_END = ID_BASE + 12'(ID_COUNT - 1);

  logic [4:0] idx;
  logic       hpm_ok, id_hit, user_hit, mcnt_hit, mevt_hit, men_hit;
  logic       wr_intent, ro_space;

  assign idx    = csr_addr[4:0];
  assign hpm_ok = (idx >= 5'd3) && (idx <= TOP5);

  assign id_hit   = (csr_addr >= ID_BASE) && (csr_addr <= ID_END);
  assign user_hit = (csr_addr[11:8] == 4'hC) && (csr_addr[6:5] == 2'b00) && (idx <= TOP5);
  assign mcnt_hit = (csr_addr[11:8] == 4'hB) && (csr_addr[6:5] == 2'b00) && hpm_ok;
  assign mevt_hit = (csr_addr[11:5] == 7'b0011001) && hpm_ok;
  assign men_hit  = (csr_addr == 12'h306);

  assign csr_defined = id_hit | user_hit | mcnt_hit | mevt_hit | men_hit;

  assign wr_intent = (op_kind == 2'b01) | (op_kind[1] & src_nonzero);
  assign ro_space  = (csr_addr[11:10] == 2'b11);

  assign raise_exc = ~csr_defined | (wr_intent & ro_space);
endmodule

module csr_perm_check_sva (
  input logic [11:0] csr_addr,
  input logic [1:0]  op_kind,
  input logic        src_nonzero,
  input logic        csr_defined,
  input logic        raise_exc
);
  always_comb begin
    if (!$isunknown({csr_addr, op_kind, src_nonzero, csr_defined, raise_exc})) begin
      // R8
      undef_trap_chk: assert (csr_defined || raise_exc);
      // R7
      read_clean_chk: assert (!(csr_defined && op_kind == 2'b00) || !raise_exc);
      // R6
      rw_space_chk: assert (!(csr_defined && csr_addr[11:10] != 2'b11) || !raise_exc);
      // R7
      zero_src_chk: assert (!(csr_defined && op_kind[1] && !src_nonzero) || !raise_exc);
      // R1
      ro_write_chk: assert (!(csr_defined && csr_addr[11:10] == 2'b11 &&
                              (op_kind == 2'b01 || (op_kind[1] && src_nonzero))) || raise_exc);
    end
  end
endmodule

bind csr_perm_check csr_perm_check_sva u_sva (
  .csr_addr(csr_addr), .op_kind(op_kind), .src_nonzero(src_nonzero),
  .csr_defined(csr_defined), .raise_exc(raise_exc)
);

// File: tb/test_csr_perm_check.sv
module test_csr_perm_check;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [11:0] csr_addr = '0;
  logic [1:0]  op_kind = '0;
  logic        src_nonzero = 1'b0;
  logic        csr_defined, raise_exc;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  csr_perm_check i_csr_perm_check (
    .csr_addr(csr_addr), .op_kind(op_kind), .src_nonzero(src_nonzero),
    .csr_defined(csr_defined), .raise_exc(raise_exc)
  );

  task automatic probe(input logic [11:0] a, input logic [1:0] k, input logic nz,
                       input logic exp_def, input logic exp_exc, input string req);
    @(negedge clk);
    csr_addr = a; op_kind = k; src_nonzero = nz;
    #1;
    checks++;
    if (csr_defined !== exp_def || raise_exc !== exp_exc) begin
      failures++;
      $display("FAIL %s addr=%h op=%0d nz=%0d actual def=%b exc=%b expected def=%b exc=%b",
               req, a, k, nz, csr_defined, raise_exc, exp_def, exp_exc);
    end
  endtask

  task automatic t_idle();
    probe(12'h000, 2'b00, 1'b0, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_id_regs();
    for (int a = 'hF11; a <= 'hF14; a++) begin
      probe(12'(a), 2'b00, 1'b0, 1'b1, 1'b0, "R1");
      probe(12'(a), 2'b01, 1'b0, 1'b1, 1'b1, "R1");
      probe(12'(a), 2'b10, 1'b1, 1'b1, 1'b1, "R1");
    end
  endtask

  task automatic t_cycle_instret();
    probe(12'hC00, 2'b01, 1'b0, 1'b1, 1'b1, "R2");
    probe(12'hC80, 2'b11, 1'b1, 1'b1, 1'b1, "R2");
    probe(12'hC02, 2'b10, 1'b1, 1'b1, 1'b1, "R2");
    probe(12'hC82, 2'b01, 1'b1, 1'b1, 1'b1, "R2");
  endtask

  task automatic t_timer();
    probe(12'hC01, 2'b00, 1'b0, 1'b1, 1'b0, "R3");
    probe(12'hC81, 2'b10, 1'b0, 1'b1, 1'b0, "R3");
  endtask

  task automatic t_user_hpm();
    for (int i = 3; i <= 31; i++) begin
      probe(12'hC00 + 12'(i), 2'b00, 1'b0, 1'b1, 1'b0, "R4");
      probe(12'hC80 + 12'(i), 2'b00, 1'b0, 1'b1, 1'b0, "R4");
    end
  endtask

  task automatic t_machine_cnt();
    probe(12'h306, 2'b00, 1'b0, 1'b1, 1'b0, "R5");
    probe(12'h306, 2'b01, 1'b1, 1'b1, 1'b0, "R6");
    for (int i = 3; i <= 31; i++) begin
      probe(12'hB00 + 12'(i), 2'b00, 1'b0, 1'b1, 1'b0, "R5");
      probe(12'hB80 + 12'(i), 2'b00, 1'b0, 1'b1, 1'b0, "R5");
      probe(12'h320 + 12'(i), 2'b00, 1'b0, 1'b1, 1'b0, "R5");
      probe(12'hB00 + 12'(i), 2'b01, 1'b1, 1'b1, 1'b0, "R6");
      probe(12'h320 + 12'(i), 2'b11, 1'b1, 1'b1, 1'b0, "R6");
    end
  endtask

  task automatic t_intent();
    probe(12'hC00, 2'b10, 1'b0, 1'b1, 1'b0, "R7");
    probe(12'hC00, 2'b11, 1'b0, 1'b1, 1'b0, "R7");
    probe(12'hF11, 2'b00, 1'b1, 1'b1, 1'b0, "R7");
    probe(12'hF12, 2'b01, 1'b0, 1'b1, 1'b1, "R7");
    probe(12'hF13, 2'b11, 1'b1, 1'b1, 1'b1, "R7");
  endtask

  task automatic t_undefined();
    logic [11:0] holes [8] = '{12'hB00, 12'hB02, 12'h320, 12'h322, 12'hF15,
                               12'hF10, 12'hCA0, 12'h305};
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 4; k++)
        probe(holes[j], 2'(k), 1'b0, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_defined_flag();
    probe(12'hC1F, 2'b01, 1'b1, 1'b1, 1'b1, "R9");
    probe(12'hB9F, 2'b11, 1'b0, 1'b1, 1'b0, "R9");
    probe(12'hB20, 2'b00, 1'b0, 1'b0, 1'b1, "R9");
    probe(12'h340, 2'b00, 1'b0, 1'b0, 1'b1, "R9");
  endtask

  initial begin
    fork
      begin
        t_idle();
        t_id_regs();
        t_cycle_instret();
        t_timer();
        t_user_hpm();
        t_machine_cnt();
        t_intent();
        t_undefined();
        t_defined_flag();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule